// File: doc/BRIEF.md
# SMBus Target Register Responder

This block is the target side of a two-wire system-management bus. It watches the clock and data lines from the bus and finds start, repeated start and stop conditions. When it sees its own 7-bit address, it answers with an ack. It then serves a small internal bank of byte registers, which the controller addresses through a command byte. It never drives a line high. It only pulls the data line low, and only for acknowledges and for zero bits of read data. It does not stretch the clock, and it does not handle 10-bit addresses or address resolution.

The first byte written after the address is the command. Its low bits select a register, and its top bit picks block mode. In plain mode, data bytes written after the command go to consecutive registers, and reads return consecutive registers. So one mechanism covers byte and word transfers, with the low byte first. In block mode, a write carries a count byte ahead of its data. A read in block mode answers with a fixed count byte and then the data. The command is kept after the transaction ends. A later read that sends no command starts at the register that command chose.

The controller of the state machine has eight states:
- `ST_IDLE` waits for a start.
- `ST_ADDR` shifts in the address byte.
- `ST_ADDR_ACK` drives the address ack.
- `ST_WR` shifts in a written byte.
- `ST_WR_ACK` drives the ack for that byte.
- `ST_RD` shifts out a read byte.
- `ST_RD_ACK` samples the controller's ack.
- `ST_HOLD` stays silent until the next start or stop.

The transitions are:
- A start moves any state to `ST_ADDR`, and a stop moves any state to `ST_IDLE`.
- From `ST_ADDR`, a matching address leads to `ST_ADDR_ACK`, and any other address leads to `ST_HOLD`.
- From `ST_ADDR_ACK`, the state moves to `ST_WR` or `ST_RD` by the direction bit.
- The pairs `ST_WR`/`ST_WR_ACK` and `ST_RD`/`ST_RD_ACK` alternate for each byte.
- From `ST_RD_ACK`, a nack leads to `ST_HOLD`.

Top module: `smb_reg_target`

## Requirements
- R1: Both lines pass through a two-flop synchroniser. A start is a data fall while the clock is high, and it begins an address phase from any state. A stop is a data rise while the clock is high. It returns the block to idle with the data line released.
- R2: The block acks an address byte whose upper seven bits equal `OWN_ADDR` (default 7'h3A), with bit 0 as the direction (1 = read). For any other address it gives no ack and pulls nothing until the next start or stop.
- R3: The first byte written after the address is the command. Bits [IW-1:0] are the register index, and bit 7 is the block flag. A command followed by a stop only sets the pointer. Every written byte is acked.
- R4: In plain mode, the data bytes that follow the command are stored in consecutive registers, starting at the selected one. The low byte of a word comes first, and the index wraps modulo `NREGS`.
- R5: A repeated start after the command turns the transaction into a read. The first byte is the selected register, and each further acked byte is the next register.
- R6: A read with no command first starts at the register of the most recent command. Earlier auto-increments do not move that start point.
- R7: In block mode, a read sends the count `BLK_LEN` (default 4) first, and then the registers from the selected one onward.
- R8: In block mode, the first data byte of a write is a count, capped at 32. That many following bytes are stored from the selected register. Bytes beyond the count are acked but not stored.
- R9: A nack from the controller on a read byte ends the read. The block then pulls nothing until the next start or stop.
- R10: The data line is only ever pulled low, and the pull changes only while the clock is low. After reset the line is released and register i holds `INIT_SEED + i` (default 8'h40 + i).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin (wired-AND of all drivers) |
| sda_pull | output | 1 | 1 pulls the data line low; 0 releases it |

## Verification
A wrong bit counter or a wrong state shows up within one byte. An ack lands on the wrong clock pulse, or the next read byte comes out shifted, and the controller's next sampled bit shows it. A wrong pointer or a lost command shows up on the first byte read back in the following transaction. A count handled wrongly in block mode shows up as a stored byte that should have been dropped, or as a wrong count byte at the head of a block read. Both are seen within the next read transaction.

// File: rtl/smb_pkg.sv
package smb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR,
        ST_WR_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_HOLD
    } smb_state_t;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_m, sda_m, scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_m <= 1'b1;
            sda_m <= 1'b1;
            scl_s <= 1'b1;
            sda_s <= 1'b1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_m <= scl_in;
            sda_m <= sda_in;
            scl_s <= scl_m;
            sda_s <= sda_m;
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
    parameter int         NREGS     = 16,
    parameter logic [7:0] INIT_SEED = 8'h40,
    localparam int        IW        = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] ridx,
    output logic [7:0]    rdata
);
    logic [7:0] mem [NREGS];

    for (genvar gi = 0; gi < NREGS; gi++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[gi] <= 8'(INIT_SEED + gi);
            else if (we && widx == IW'(gi))
                mem[gi] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/smb_reg_target.sv
module smb_reg_target #(
    parameter logic [6:0] OWN_ADDR  = 7'h3A,
    parameter int         NREGS     = 16,
    parameter logic [7:0] INIT_SEED = 8'h40,
    parameter int         BLK_LEN   = 4,
    parameter int         MAX_BLK   = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_pull
);
    import smb_pkg::*;

    localparam int         IW      = $clog2(NREGS);
    localparam int         CW      = $clog2(MAX_BLK + 1);
    localparam logic [3:0] LAST_RX = 4'd8;
    localparam logic [3:0] LAST_TX = 4'd7;
    localparam logic [7:0] CAP8    = 8'(MAX_BLK);
    localparam logic [7:0] CNT8    = 8'(BLK_LEN);

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    smb_state_t st, st_nx;
    logic [3:0]    cnt;
    logic [7:0]    sh;
    logic          rw_q, acked, rd_first;
    logic          cmd_blk, got_cmd, got_cnt;
    logic [IW-1:0] cmd_idx, ptr;
    logic [CW-1:0] blk_left;
    logic [7:0]    rd_data;
    logic          wr_en, rx_done, match;

    smb_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_ev(start_ev), .stop_ev(stop_ev)
    );

    smb_regbank #(.NREGS(NREGS), .INIT_SEED(INIT_SEED)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(wr_en), .widx(ptr), .wdata(sh),
        .ridx(ptr), .rdata(rd_data)
    );

    assign rx_done = scl_fall && cnt == LAST_RX;
    assign match   = sh[7:1] == OWN_ADDR;
    assign wr_en   = st == ST_WR && rx_done && got_cmd &&
                     (!cmd_blk || (got_cnt && blk_left != '0));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        if (stop_ev)
            st_nx = ST_IDLE;
        else if (start_ev)
            st_nx = ST_ADDR;
        else begin
            unique case (st)
                ST_IDLE:     ;
                ST_ADDR:     if (rx_done) st_nx = match ? ST_ADDR_ACK : ST_HOLD;
                ST_ADDR_ACK: if (scl_fall) st_nx = rw_q ? ST_RD : ST_WR;
                ST_WR:       if (rx_done) st_nx = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) st_nx = ST_WR;
                ST_RD:       if (scl_fall && cnt == LAST_TX) st_nx = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) st_nx = acked ? ST_RD : ST_HOLD;
                ST_HOLD:     ;
            endcase
        end
    end

    // datapath: shifting, command pointer, block counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            sh       <= '0;
            rw_q     <= 1'b0;
            acked    <= 1'b0;
            rd_first <= 1'b0;
            cmd_blk  <= 1'b0;
            cmd_idx  <= '0;
            got_cmd  <= 1'b0;
            got_cnt  <= 1'b0;
            ptr      <= '0;
            blk_left <= '0;
        end else if (start_ev || stop_ev) begin
            cnt <= '0;
        end else begin
            unique case (st)
                ST_ADDR, ST_WR: begin
                    if (scl_rise && cnt != LAST_RX) begin
                        sh  <= {sh[6:0], sda_s};
                        cnt <= cnt + 4'd1;
                    end
                    if (rx_done) begin
                        cnt <= '0;
                        if (st == ST_ADDR) begin
                            if (match) begin
                                rw_q     <= sh[0];
                                ptr      <= cmd_idx;
                                rd_first <= 1'b1;
                                got_cmd  <= 1'b0;
                                got_cnt  <= 1'b0;
                            end
                        end else if (!got_cmd) begin
                            cmd_blk <= sh[7];
                            cmd_idx <= sh[IW-1:0];
                            ptr     <= sh[IW-1:0];
                            got_cmd <= 1'b1;
                        end else if (cmd_blk && !got_cnt) begin
                            blk_left <= (sh > CAP8) ? CW'(MAX_BLK) : CW'(sh);
                            got_cnt  <= 1'b1;
                        end else if (wr_en) begin
                            ptr <= ptr + 1'b1;
                            if (cmd_blk) blk_left <= blk_left - 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK, ST_RD_ACK: begin
                    if (st == ST_RD_ACK && scl_rise) acked <= ~sda_s;
                    if (scl_fall && (st == ST_ADDR_ACK ? rw_q : acked)) begin
                        rd_first <= 1'b0;
                        if (rd_first && cmd_blk) sh <= CNT8;
                        else begin
                            sh  <= rd_data;
                            ptr <= ptr + 1'b1;
                        end
                    end
                end
                ST_RD: begin
                    if (scl_fall) begin
                        if (cnt == LAST_TX) cnt <= '0;
                        else begin
                            sh  <= {sh[6:0], 1'b0};
                            cnt <= cnt + 4'd1;
                        end
                    end
                end
                ST_IDLE, ST_WR_ACK, ST_HOLD: ;
            endcase
        end
    end

    // output logic
    always_comb begin
        unique case (st)
            ST_ADDR_ACK, ST_WR_ACK: sda_pull = 1'b1;
            ST_RD:                  sda_pull = ~sh[7];
            default:                sda_pull = 1'b0;
        endcase
    end
endmodule

module smb_reg_target_chk (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_s,
    input logic               start_ev,
    input logic               stop_ev,
    input logic               sda_pull,
    input smb_pkg::smb_state_t st
);
    import smb_pkg::*;

    // R1
    start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && !stop_ev) |=> st == ST_ADDR);

    // R1
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (st == ST_IDLE && !sda_pull));

    // R2
    quiet_states_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE || st == ST_ADDR || st == ST_HOLD) |-> !sda_pull);

    // R9
    ctl_ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_RD_ACK |-> !sda_pull);

    // R10
    pull_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> !scl_s);
endmodule

bind smb_reg_target smb_reg_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_ev(start_ev),
    .stop_ev(stop_ev), .sda_pull(sda_pull), .st(st)
);

// File: tb/smb_reg_target_tb.sv
module smb_reg_target_tb;
    localparam int         Q   = 8;
    localparam logic [6:0] OWN = 7'h3A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_c = 1'b1;
    logic sda_pull;
    logic sda_bus;

    always #5 clk = ~clk;
    assign sda_bus = sda_c & ~sda_pull;

    smb_reg_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus), .sda_pull(sda_pull)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] obs;
    event       obs_ev;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic t_start();
        sda_c = 1'b1; qw(); scl = 1'b1; qw(); sda_c = 1'b0; qw(); scl = 1'b0; qw();
    endtask

    task automatic t_stop();
        sda_c = 1'b0; qw(); scl = 1'b1; qw(); sda_c = 1'b1; qw();
    endtask

    task automatic t_bit_out(input logic b);
        sda_c = b; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
    endtask

    task automatic t_bit_in(output logic b);
        sda_c = 1'b1; qw(); scl = 1'b1; qw(); b = sda_bus; qw(); scl = 1'b0; qw();
    endtask

    task automatic t_wr(input logic [7:0] d, input bit exp_ack, input string tag);
        logic a;
        for (int i = 7; i >= 0; i--) t_bit_out(d[i]);
        t_bit_in(a);
        chk((!a) == exp_ack, tag, !a, exp_ack);
    endtask

    task automatic t_addr(input logic [6:0] a, input logic rd, input bit exp_ack, input string tag);
        t_wr({a, rd}, exp_ack, tag);
    endtask

    // driver side of the scoreboard: push expectation, then clock the byte in
    task automatic t_rd(input logic [7:0] e, input bit last, input string tag);
        logic [7:0] d;
        logic b;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        for (int i = 7; i >= 0; i--) begin
            t_bit_in(b);
            d[i] = b;
        end
        obs = d;
        -> obs_ev;
        t_bit_out(last);
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            @(obs_ev);
            if (exp_q.size() == 0) chk(1'b0, "scoreboard-empty", obs, 0);
            else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(obs == e, t, obs, e);
            end
        end
    end

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic b;
        bit quiet;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        qw();
        // R10: released after reset
        chk(sda_pull == 1'b0, "R10 reset release", sda_pull, 0);

        // R2 R3 R4: write byte 0x11 to register 2
        t_start();
        t_addr(OWN, 1'b0, 1'b1, "R2 own address ack");
        t_wr(8'h02, 1'b1, "R3 command ack");
        t_wr(8'h11, 1'b1, "R3 data ack");
        t_stop();
        // R1 R5: read it back through a repeated start
        t_start(); t_addr(OWN, 1'b0, 1'b1, "R2 ack");
        t_wr(8'h02, 1'b1, "R3 ack");
        t_start(); t_addr(OWN, 1'b1, 1'b1, "R1 repeated start ack");
        t_rd(8'h11, 1'b1, "R5 read byte reg2");
        t_stop();

        // R4: write word low first to register 5
        t_start(); t_addr(OWN, 1'b0, 1'b1, "R2 ack");
        t_wr(8'h05, 1'b1, "R3 ack");
        t_wr(8'h34, 1'b1, "R4 low ack");
        t_wr(8'h12, 1'b1, "R4 high ack");
        t_stop();
        t_start(); t_addr(OWN, 1'b0, 1'b1, "R2 ack");
        t_wr(8'h05, 1'b1, "R3 ack");
        t_start(); t_addr(OWN, 1'b1, 1'b1, "R5 ack");
        t_rd(8'h34, 1'b0, "R4 R5 word low");
        t_rd(8'h12, 1'b1, "R4 R5 word high");
        t_stop();

        // R6: receive byte twice, pointer stays at register 5
        t_start(); t_addr(OWN, 1'b1, 1'b1, "R6 ack");
        t_rd(8'h34, 1'b1, "R6 receive byte first");
        t_stop();
        t_start(); t_addr(OWN, 1'b1, 1'b1, "R6 ack");
        t_rd(8'h34, 1'b1, "R6 receive byte repeat");
        t_stop();

        // R3 R6: send byte sets pointer to 7 (reset value 0x47)
        t_start(); t_addr(OWN, 1'b0, 1'b1, "R3 ack");
        t_wr(8'h07, 1'b1, "R3 send byte ack");
        t_stop();
        t_start(); t_addr(OWN, 1'b1, 1'b1, "R6 ack");
        t_rd(8'h47, 1'b1, "R3 R6 receive after send byte");
        t_stop();

        // R2: foreign address gets no ack and no pull for a whole byte
        t_start();
        t_addr(7'h21, 1'b1, 1'b0, "R2 foreign nack");
        quiet = 1'b1;
        for (int i = 0; i < 9; i++) begin
            t_bit_in(b);
            if (!b) quiet = 1'b0;
        end
        chk(quiet, "R2 foreign silent", quiet, 1);
        t_stop();

        // R8: block write, count 3, one extra byte dropped
        t_start(); t_addr(OWN, 1'b0, 1'b1, "R8 ack");
        t_wr(8'h88, 1'b1, "R8 block command ack");
        t_wr(8'h03, 1'b1, "R8 count ack");
        t_wr(8'hA1, 1'b1, "R8 data ack");
        t_wr(8'hA2, 1'b1, "R8 data ack");
        t_wr(8'hA3, 1'b1, "R8 data ack");
        t_wr(8'hB4, 1'b1, "R8 extra byte ack");
        t_stop();
        t_start(); t_addr(OWN, 1'b0, 1'b1, "R8 ack");
        t_wr(8'h08, 1'b1, "R8 ack");
        t_start(); t_addr(OWN, 1'b1, 1'b1, "R8 ack");
        t_rd(8'hA1, 1'b0, "R8 stored 0");
        t_rd(8'hA2, 1'b0, "R8 stored 1");
        t_rd(8'hA3, 1'b0, "R8 stored 2");
        t_rd(8'h4B, 1'b1, "R8 extra not stored");
        t_stop();

        // R7 R9: block read, count first, nack then silence
        t_start(); t_addr(OWN, 1'b0, 1'b1, "R7 ack");
        t_wr(8'h88, 1'b1, "R7 ack");
        t_start(); t_addr(OWN, 1'b1, 1'b1, "R7 ack");
        t_rd(8'h04, 1'b0, "R7 count byte");
        t_rd(8'hA1, 1'b0, "R7 data 0");
        t_rd(8'hA2, 1'b0, "R7 data 1");
        t_rd(8'hA3, 1'b0, "R7 data 2");
        t_rd(8'h4B, 1'b1, "R7 data 3");
        quiet = 1'b1;
        for (int i = 0; i < 9; i++) begin
            t_bit_in(b);
            if (!b) quiet = 1'b0;
        end
        chk(quiet, "R9 silent after nack", quiet, 1);
        t_stop();
        chk(sda_pull == 1'b0, "R1 released after stop", sda_pull, 0);

        // R4: word write wraps from register 15 to register 0
        t_start(); t_addr(OWN, 1'b0, 1'b1, "R4 ack");
        t_wr(8'h0F, 1'b1, "R4 ack");
        t_wr(8'h55, 1'b1, "R4 ack");
        t_wr(8'h66, 1'b1, "R4 ack");
        t_start(); t_addr(OWN, 1'b1, 1'b1, "R4 ack");
        t_rd(8'h55, 1'b0, "R4 wrap reg15");
        t_rd(8'h66, 1'b1, "R4 wrap reg0");
        t_stop();

        qw();
        chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule